// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Slave

This block sits between a clocked logic core and the external bus of a small 8-bit microcontroller. On that bus the low address byte and the data share one bidirectional 8-bit bus, and the high address byte has pins of its own. The master opens each cycle by pulling an active-low address-latch strobe. It then pulses an active-low read, write or program-store strobe. The slave samples every strobe through a synchroniser into its own clock domain. It keeps a pipelined copy of both address buses that is aligned with the synchroniser. Using that copy, it recovers the 16-bit address as it stood just before the latch strobe fell, and the write data as it stood just before the write strobe rose.

Three registers sit in one 256-byte window whose high byte is a parameter (default 0x80). The core reads the input data register, which the master writes. The application loads the output data register, which the master reads. A status register carries two handshake flags and an error line. The data-ready flag tells the master that the application has loaded fresh output. The need-data flag tells the master that the application wants a new input word. The master clears either flag by writing a one to its status bit. Each flag also has a clear from the application side, and the need-data clear acts asynchronously. Instruction fetches, marked by the program-store strobe, are never answered.

Top module: `mcu_bus_slave`

## Requirements
- R1: While `rst` is high and after it falls, `in_data`, the output data register, `data_rdy` and `need_data` are 0 and `ad_oe` is 0.
- R2: The falling edge of `ale_n` captures the 16-bit address {`addr_hi`, `ad_in`} as sampled before that edge. The capture completes SYNC_STAGES+1 clock edges after the fall, and the captured address is unaffected by later activity on `ad_in`.
- R3: A write to address {BASE_HI, 0x00} loads the `ad_in` value seen just before `wr_n` rose into `in_data`. The load takes effect on the (SYNC_STAGES+1)-th rising clock edge after `wr_n` rises.
- R4: During a read of {BASE_HI, 0x01}, `ad_out` carries the output data register. During a read of {BASE_HI, 0x02}, `ad_out` carries status: bit0 data-ready, bit1 need-data, bit2 `err_in`, other bits 0. `ad_oe` rises SYNC_STAGES clock edges after `rd_n` falls and drops SYNC_STAGES edges after `rd_n` rises.
- R5: While `psen_n` is low, `ad_oe` stays 0 even if `rd_n` is also low.
- R6: A read of any address outside the three readable offsets leaves `ad_oe` at 0. This covers the wrong high byte, offset 0x00 and offsets above 0x02.
- R7: `data_rdy` is set on the clock after `out_load` is high while `app_en` is high. It is cleared by `rdy_clr` or by a bus write of bit0 = 1 to offset 0x02, and a set in the same cycle beats a clear. `out_load` always loads `out_data` into the output register, but with `app_en` low it leaves the flag unchanged.
- R8: `need_data` is set by `need_set` and cleared by a bus write of bit1 = 1 to offset 0x02, with set beating that clear. `need_clr` clears it at once, without waiting for a clock edge, and overrides `need_set`.
- R9: Outside a read cycle (`rd_n` high for at least SYNC_STAGES edges), `ad_oe` is 0.
- R10: Writes to offset 0x01, to offsets outside the window, or of zero bits to status change neither `in_data` nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| addr_hi | input | 8 | High address byte from the master |
| ad_in | input | 8 | Shared address/data bus, input side |
| ad_out | output | 8 | Shared bus, read data driven by the slave |
| ad_oe | output | 1 | Tri-state enable for `ad_out` |
| ale_n | input | 1 | Address-latch strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| psen_n | input | 1 | Program-store (fetch) strobe, active low |
| app_en | input | 1 | Application enabled; qualifies data-ready set |
| out_load | input | 1 | Load `out_data` into the output register |
| out_data | input | 8 | Data from the application |
| rdy_clr | input | 1 | Synchronous clear of data-ready |
| need_set | input | 1 | Application requests a new input word |
| need_clr | input | 1 | Asynchronous clear of need-data |
| err_in | input | 1 | Error line shown in status bit2 |
| in_data | output | 8 | Input data register contents |
| data_rdy | output | 1 | Data-ready flag |
| need_data | output | 1 | Need-data flag |

## Verification
The bench builds the block with SYNC_STAGES = 2 and BASE_HI = 0x80. The window therefore sits at 0x8000 to 0x8002, and every write lands on the third clock edge after `wr_n` rises. With that short latency, the behavioural model can schedule each commit from a simple countdown. It can then compare the flags and `in_data` on every clock. Each read is also checked for the exact cycle in which `ad_oe` turns on and off. Holding `need_set` high across a status write and a `need_clr` pulse shows both priority rules. Raising `out_load` and `rdy_clr` in the same cycle shows the set-over-clear rule for data-ready.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [1:0] {SEL_NONE, SEL_IN, SEL_OUT, SEL_STAT} sel_e;

  localparam logic [7:0] OFF_IN   = 8'h00;
  localparam logic [7:0] OFF_OUT  = 8'h01;
  localparam logic [7:0] OFF_STAT = 8'h02;

  // Map a latched 16-bit address to a register select.
  function automatic sel_e decode_sel(input logic [15:0] a, input logic [7:0] base_hi);
    if (a[15:8] != base_hi) return SEL_NONE;
    case (a[7:0])
      OFF_IN:   return SEL_IN;
      OFF_OUT:  return SEL_OUT;
      OFF_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

  function automatic logic is_readable(input sel_e s);
    return (s == SEL_OUT) || (s == SEL_STAT);
  endfunction

  // Status byte layout: bit0 ready, bit1 need, bit2 error.
  function automatic logic [7:0] pack_status(input logic rdy, input logic need, input logic err);
    return {5'b0, err, need, rdy};
  endfunction

endpackage

// File: rtl/mbs_pipe.sv
module mbs_pipe #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge rst)
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or posedge rst)
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/mbs_front.sv
module mbs_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr_hi,
  input  logic [7:0]  ad_in,
  input  logic        ale_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        psen_n,
  output logic [15:0] lat_addr,
  output logic [7:0]  wdata,
  output logic        wr_commit,
  output logic        latch_ev,
  output logic        rd_active,
  output logic        fetch_active
);
  localparam int BUS_DEPTH = SYNC_STAGES + 1;

  logic [3:0]  s_cur;      // {psen_n, wr_n, rd_n, ale_n} after sync
  logic [1:0]  s_prv;      // {wr_n, ale_n} one edge older
  logic [15:0] bus_al;     // bus sample aligned with s_prv

  mbs_pipe #(.W(4), .DEPTH(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
    .clk(clk), .rst(rst), .d({psen_n, wr_n, rd_n, ale_n}), .q(s_cur));

  mbs_pipe #(.W(16), .DEPTH(BUS_DEPTH), .RST_VAL(16'h0)) u_bus (
    .clk(clk), .rst(rst), .d({addr_hi, ad_in}), .q(bus_al));

  always_ff @(posedge clk or posedge rst)
    if (rst) s_prv <= 2'b11;
    else     s_prv <= {s_cur[2], s_cur[0]};

  assign latch_ev     = s_prv[0] & ~s_cur[0];
  assign wr_commit    = ~s_prv[1] & s_cur[2];
  assign rd_active    = ~s_cur[1];
  assign fetch_active = ~s_cur[3];
  assign wdata        = bus_al[7:0];

  always_ff @(posedge clk or posedge rst)
    if (rst)           lat_addr <= '0;
    else if (latch_ev) lat_addr <= bus_al;

  // R2: the latched address is the bus as it stood before the strobe fell
  a_r2_latch_capture: assert property (@(posedge clk) disable iff (rst)
    latch_ev |=> lat_addr == $past(bus_al));

  // R3: a commit is a single-cycle event per rising write strobe
  a_r3_commit_one_shot: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/mbs_regs.sv
module mbs_regs
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sel_e       sel,
  input  logic       wr_commit,
  input  logic [7:0] wdata,
  input  logic       app_en,
  input  logic       out_load,
  input  logic [7:0] out_data,
  input  logic       rdy_clr,
  input  logic       need_set,
  input  logic       need_clr,
  input  logic       err_in,
  output logic [7:0] in_data,
  output logic [7:0] rd_word,
  output logic       data_rdy,
  output logic       need_data
);
  logic [7:0] out_reg;
  logic       wr_in, wr_stat, need_arst;

  assign wr_in     = wr_commit && (sel == SEL_IN);
  assign wr_stat   = wr_commit && (sel == SEL_STAT);
  assign need_arst = rst | need_clr;

  always_ff @(posedge clk or posedge rst)
    if (rst)        in_data <= '0;
    else if (wr_in) in_data <= wdata;

  always_ff @(posedge clk or posedge rst)
    if (rst)           out_reg <= '0;
    else if (out_load) out_reg <= out_data;

  always_ff @(posedge clk or posedge rst)
    if (rst)                              data_rdy <= 1'b0;
    else if (out_load && app_en)          data_rdy <= 1'b1;
    else if (rdy_clr || (wr_stat && wdata[0])) data_rdy <= 1'b0;

  always_ff @(posedge clk or posedge need_arst)
    if (need_arst)                  need_data <= 1'b0;
    else if (need_set)              need_data <= 1'b1;
    else if (wr_stat && wdata[1])   need_data <= 1'b0;

  assign rd_word = (sel == SEL_STAT) ? pack_status(data_rdy, need_data, err_in) : out_reg;

  // R7: a qualified load always raises data-ready
  a_r7_rdy_set: assert property (@(posedge clk) disable iff (rst)
    (out_load && app_en) |=> data_rdy);

  // R8: the asynchronous clear holds need-data low
  a_r8_need_async_clear: assert property (@(posedge clk) disable iff (rst)
    need_clr |-> !need_data);

  // R3: a commit to the input register lands the bus data
  a_r3_in_write: assert property (@(posedge clk) disable iff (rst)
    wr_in |=> in_data == $past(wdata));
endmodule

// File: rtl/mcu_bus_slave.sv
module mcu_bus_slave
  import mbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] BASE_HI = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr_hi,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  input  logic       ale_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       psen_n,
  input  logic       app_en,
  input  logic       out_load,
  input  logic [7:0] out_data,
  input  logic       rdy_clr,
  input  logic       need_set,
  input  logic       need_clr,
  input  logic       err_in,
  output logic [7:0] in_data,
  output logic       data_rdy,
  output logic       need_data
);
  logic [15:0] lat_addr;
  logic [7:0]  wdata;
  logic        wr_commit, latch_ev, rd_active, fetch_active;
  sel_e        sel;

  mbs_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .ad_in(ad_in),
    .ale_n(ale_n), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
    .lat_addr(lat_addr), .wdata(wdata), .wr_commit(wr_commit),
    .latch_ev(latch_ev), .rd_active(rd_active), .fetch_active(fetch_active));

  assign sel = decode_sel(lat_addr, BASE_HI);

  mbs_regs u_regs (
    .clk(clk), .rst(rst), .sel(sel), .wr_commit(wr_commit), .wdata(wdata),
    .app_en(app_en), .out_load(out_load), .out_data(out_data),
    .rdy_clr(rdy_clr), .need_set(need_set), .need_clr(need_clr),
    .err_in(err_in), .in_data(in_data), .rd_word(ad_out),
    .data_rdy(data_rdy), .need_data(need_data));

  // Drive only for a decoded read, never while a fetch strobe is seen.
  assign ad_oe = rd_active && !fetch_active && psen_n && is_readable(sel);

  // R9: the address feeding the read mux never moves while driving
  a_r9_addr_stable_drive: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $stable(lat_addr));

  // R2: no new address is latched in the middle of a read drive
  a_r2_no_latch_drive: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !latch_ev);
endmodule

// File: tb/sim_mcu_bus_slave.sv
`timescale 1ns/1ps
module sim_mcu_bus_slave;
  localparam int LAT = 3;   // SYNC_STAGES + 1

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] addr_hi = 0, ad_in = 0, out_data = 0;
  logic ale_n = 1, rd_n = 1, wr_n = 1, psen_n = 1;
  logic app_en = 0, out_load = 0, rdy_clr = 0, need_set = 0, need_clr = 0, err_in = 0;
  logic [7:0] ad_out, in_data;
  logic ad_oe, data_rdy, need_data;

  int checks = 0, errors = 0;
  bit in_read = 0, finished = 0;

  // reference model state
  logic [7:0] m_in = 0, m_out = 0;
  logic m_rdy = 0, m_need = 0;
  int wr_cnt = 0;
  logic [15:0] w_addr;
  logic [7:0] w_data;

  always #2 clk = ~clk;

  mcu_bus_slave #(.SYNC_STAGES(2), .BASE_HI(8'h80)) u0 (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale_n(ale_n), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
    .app_en(app_en), .out_load(out_load), .out_data(out_data), .rdy_clr(rdy_clr),
    .need_set(need_set), .need_clr(need_clr), .err_in(err_in), .in_data(in_data),
    .data_rdy(data_rdy), .need_data(need_data));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    logic [7:0] clr;
    clr = 8'h00;
    if (rst) begin
      m_in = 0; m_out = 0; m_rdy = 0; m_need = 0; wr_cnt = 0;
    end else begin
      if (wr_cnt > 0) begin
        wr_cnt--;
        if (wr_cnt == 0) begin
          if (w_addr == 16'h8000) m_in = w_data;
          if (w_addr == 16'h8002) clr = w_data;
        end
      end
      if (out_load && app_en) m_rdy = 1;
      else if (rdy_clr || clr[0]) m_rdy = 0;
      if (need_clr) m_need = 0;
      else if (need_set) m_need = 1;
      else if (clr[1]) m_need = 0;
      if (out_load) m_out = out_data;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (!rst && !finished) begin
      chk("R3/R10 in_data", in_data, m_in);
      chk("R7 data_rdy", data_rdy, m_rdy);
      chk("R8 need_data", need_data, m_need);
      if (!in_read) chk("R9 idle ad_oe", ad_oe, 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    addr_hi = a[15:8]; ad_in = a[7:0];
    cycles(3);
    ale_n = 0;
    cycles(2);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    addr_phase(a);
    ad_in = d;
    cycles(1);
    wr_n = 0;
    cycles(3);
    wr_n = 1; w_addr = a; w_data = d; wr_cnt = LAT;
    cycles(1);
    ad_in = 8'h00;
    cycles(3);
    ale_n = 1;
    cycles(3);
  endtask

  // fetch=1 pulls psen_n low together with rd_n
  task automatic bus_read(input logic [15:0] a, input bit drive, input bit fetch, input string tag);
    logic [7:0] exp;
    in_read = 1;
    addr_phase(a);
    ad_in = 8'hEE;
    rd_n = 0;
    if (fetch) psen_n = 0;
    cycles(1);
    chk({tag, " oe before sync"}, ad_oe, 0);
    cycles(1);
    exp = (a[7:0] == 8'h02) ? {5'b0, err_in, m_need, m_rdy} : m_out;
    chk({tag, " oe"}, ad_oe, drive);
    if (drive) chk({tag, " data"}, ad_out, exp);
    cycles(2);
    rd_n = 1; psen_n = 1;
    cycles(1);
    chk({tag, " oe hold"}, ad_oe, drive);
    cycles(1);
    chk({tag, " oe release"}, ad_oe, 0);
    ale_n = 1;
    cycles(2);
    in_read = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk("R1 oe in reset", ad_oe, 0);
    chk("R1 flags in reset", {data_rdy, need_data}, 0);
    rst = 0;
    cycles(2);
    chk("R1 in_data after reset", in_data, 0);
    bus_read(16'h8001, 1, 0, "R1 out reg reset");
    bus_read(16'h8002, 1, 0, "R1 status reset");

    // R2 R3: writes into the input register
    bus_write(16'h8000, 8'h5A);
    chk("R3 write 5A", in_data, 8'h5A);
    bus_write(16'h8000, 8'hA5);
    chk("R2 R3 write A5", in_data, 8'hA5);

    // R10: writes that must not land
    bus_write(16'h8001, 8'hFF);
    bus_write(16'h9000, 8'h11);
    bus_write(16'h8003, 8'h22);
    chk("R10 in_data kept", in_data, 8'hA5);

    // R7: load without enable, then with enable
    out_data = 8'h33; out_load = 1; cycles(1); out_load = 0; cycles(1);
    chk("R7 no flag when disabled", data_rdy, 0);
    bus_read(16'h8001, 1, 0, "R4 out reg 33");
    app_en = 1;
    out_data = 8'hC3; out_load = 1; cycles(1); out_load = 0; cycles(1);
    chk("R7 flag set", data_rdy, 1);
    bus_read(16'h8001, 1, 0, "R4 out reg C3");
    err_in = 1;
    bus_read(16'h8002, 1, 0, "R4 status err+rdy");
    err_in = 0;
    rdy_clr = 1; cycles(1); rdy_clr = 0; cycles(1);
    chk("R7 rdy_clr", data_rdy, 0);

    // R7: set wins over same-cycle clear
    out_load = 1; rdy_clr = 1; cycles(1); out_load = 0; rdy_clr = 0; cycles(1);
    chk("R7 set beats clear", data_rdy, 1);

    // R8 and status write-one-to-clear
    need_set = 1; cycles(1); need_set = 0; cycles(1);
    chk("R8 need set", need_data, 1);
    bus_read(16'h8002, 1, 0, "R4 status need+rdy");
    bus_write(16'h8002, 8'h00);
    chk("R10 zero write keeps flags", {data_rdy, need_data}, 2'b11);
    bus_write(16'h8002, 8'h02);
    chk("R8 bus clear need", need_data, 0);
    chk("R7 rdy untouched by bit1", data_rdy, 1);
    bus_write(16'h8002, 8'h01);
    chk("R7 bus clear rdy", data_rdy, 0);

    need_set = 1;
    bus_write(16'h8002, 8'h02);
    chk("R8 set beats bus clear", need_data, 1);
    need_clr = 1;
    #1;
    chk("R8 async clear", need_data, 0);
    cycles(2);
    chk("R8 clear overrides set", need_data, 0);
    need_clr = 0;
    cycles(2);
    chk("R8 set after clear", need_data, 1);
    need_set = 0;
    need_clr = 1; cycles(1); need_clr = 0; cycles(1);

    // R5 R6: cycles that must never be answered
    bus_read(16'h8001, 0, 1, "R5 fetch");
    bus_read(16'h8000, 0, 0, "R6 write-only offset");
    bus_read(16'h8005, 0, 0, "R6 offset above map");
    bus_read(16'h7001, 0, 0, "R6 wrong high byte");
    bus_read(16'h8002, 1, 0, "R4 status final");

    cycles(4);
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule